// File: doc/BRIEF.md
# Block-period bit error rate monitor

This block estimates the bit error rate of a decoded stream over a programmable window of decoded bits. Each decoded bit arrives with three symbol error flags, one per generator output, which an earlier stage has already computed by re-encoding the decoded data and comparing it with the delayed input symbols. A strobe marks the cycles that carry a bit. A rate indication selects whether the third flag takes part in the bit error decision.

The window length is a multiple of a fixed inner count (1000 by default) times a 24-bit period setting. During the window, every erroneous bit feeds a truncating divide-by-8 prescaler. Each prescaler carry bumps an accumulator that saturates at its all-ones value. When the last bit of a window arrives, the accumulator value, including that last bit's own contribution, is copied to the count output. In the same edge the prescaler, the accumulator and the window counters return to zero, and an interrupt strobe is raised for one cycle. The error rate is then eight times the count divided by the window length. Software reads the count when the strobe fires. A zero period setting stops the measurement.

Top module: `ber_period_monitor`

## Requirements
- R1: After reset, `ber_count`, `ber_irq`, `sym_err` and `bit_err` are all zero.
- R2: On each clock edge where `bit_valid` is high, `sym_err` takes the value {`err_g3`, `err_g2`, `err_g1`}, with bit 0 holding the first flag. When `bit_valid` is low, it keeps its value.
- R3: On each clock edge where `bit_valid` is high, `bit_err` takes the value `err_g1 | err_g2 | (err_g3 & rate_third)`. When `bit_valid` is low, it keeps its value.
- R4: A window spans exactly INNER_MOD × `period_cfg` cycles that have `bit_valid` high. Cycles with `bit_valid` low do not advance the window.
- R5: The count latched at the end of a window equals floor(E / 8), where E is the number of valid bits in that window whose bit error was set. The remainder is discarded and does not carry into the next window.
- R6: The count saturates at 2^ACC_W − 1 (FFFF hex by default) and does not wrap.
- R7: `ber_irq` is high for exactly the one cycle after the edge that accepts the final bit of a window. `ber_count` shows the new value in that same cycle.
- R8: An error on the final bit of a window counts toward that window.
- R9: While `period_cfg` is zero, no window ends, `ber_irq` stays low, and the window counters, prescaler and accumulator are held at zero.
- R10: `ber_count` changes only in the cycle where `ber_irq` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Marks a cycle that carries one decoded bit |
| rate_third | input | 1 | High when the third symbol flag takes part in the bit error |
| err_g1 | input | 1 | Error flag of the first symbol |
| err_g2 | input | 1 | Error flag of the second symbol |
| err_g3 | input | 1 | Error flag of the third symbol |
| period_cfg | input | PERIOD_W | Window length in units of INNER_MOD bits; zero disables measurement |
| sym_err | output | 3 | Symbol error flags of the latest bit, {g3, g2, g1} |
| bit_err | output | 1 | Bit error of the latest bit |
| ber_count | output | ACC_W | Prescaled error count of the last completed window |
| ber_irq | output | 1 | One-cycle strobe that marks a new count |

## Verification
Every output is registered once, so each result is due in the cycle right after the edge that accepts the bit. The flags and the bit error reflect that bit. On a window's final bit, the strobe and the new count appear together. The bench drives each bit on the falling edge and samples one nanosecond after the next rising edge. It advances its own arithmetic model by one bit per accepted strobe. It then compares flags, strobe and count on every accepted bit and on every idle cycle. A reduced configuration (inner count 4, 8-bit accumulator) keeps windows and saturation within short runs.

// File: rtl/ber_mon_pkg.sv
package ber_mon_pkg;

  // Symbol error flags of one decoded bit.
  typedef struct packed {
    logic g3;
    logic g2;
    logic g1;
  } sym_flags_t;

  // Bit error decision: the third symbol only counts at the three-symbol rate.
  function automatic logic bit_error_of(input sym_flags_t f, input logic third);
    return f.g1 | f.g2 | (f.g3 & third);
  endfunction

endpackage

// File: rtl/ber_flag_stage.sv
module ber_flag_stage
  import ber_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_valid,
  input  logic       rate_third,
  input  sym_flags_t flags_in,
  output sym_flags_t flags_q,
  output logic       bit_err_q,
  output logic       err_event
);

  logic bit_err_now;

  assign bit_err_now = bit_error_of(flags_in, rate_third);
  assign err_event   = bit_valid & bit_err_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q   <= '0;
      bit_err_q <= 1'b0;
    end else if (bit_valid) begin
      flags_q   <= flags_in;
      bit_err_q <= bit_err_now;
    end
  end

endmodule

// File: rtl/ber_period_counter.sv
module ber_period_counter #(
  parameter int INNER_MOD = 1000,
  parameter int PERIOD_W  = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic                meas_on,
  output logic                period_end
);

  localparam int IW = (INNER_MOD > 1) ? $clog2(INNER_MOD) : 1;
  localparam logic [IW-1:0] INNER_LAST = IW'(INNER_MOD - 1);

  logic [IW-1:0]       inner_q;
  logic [PERIOD_W-1:0] outer_q;
  logic                inner_wrap;
  logic                outer_last;

  assign meas_on    = (period_cfg != '0);
  assign inner_wrap = bit_valid && (inner_q == INNER_LAST);
  // Greater-or-equal so that a shrunken setting still ends the window.
  assign outer_last = meas_on && (outer_q >= (period_cfg - PERIOD_W'(1)));
  assign period_end = meas_on && inner_wrap && outer_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (!meas_on || period_end) begin
      inner_q <= '0;
      outer_q <= '0;
    end else if (bit_valid) begin
      if (inner_wrap) begin
        inner_q <= '0;
        outer_q <= outer_q + PERIOD_W'(1);
      end else begin
        inner_q <= inner_q + IW'(1);
      end
    end
  end

endmodule

// File: rtl/ber_prescaler.sv
module ber_prescaler #(
  parameter int PRE_LOG2 = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_event,
  input  logic clear,
  output logic carry
);

  logic [PRE_LOG2-1:0] pre_q;

  assign carry = err_event && (pre_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pre_q <= '0;
    else if (clear)     pre_q <= '0;
    else if (err_event) pre_q <= pre_q + PRE_LOG2'(1);
  end

endmodule

// File: rtl/ber_accumulator.sv
module ber_accumulator #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clear,
  input  logic             period_end,
  output logic [ACC_W-1:0] acc_level,
  output logic [ACC_W-1:0] count_q,
  output logic             irq_q
);

  logic [ACC_W-1:0] acc_next;

  // Increment that stops at all ones instead of wrapping.
  function automatic logic [ACC_W-1:0] sat_inc(input logic [ACC_W-1:0] v, input logic en);
    if (en && (v != '1)) return v + ACC_W'(1);
    return v;
  endfunction

  assign acc_next = sat_inc(acc_level, inc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_level <= '0;
      count_q   <= '0;
      irq_q     <= 1'b0;
    end else begin
      irq_q <= period_end;
      if (period_end) begin
        count_q   <= acc_next;
        acc_level <= '0;
      end else if (clear) begin
        acc_level <= '0;
      end else begin
        acc_level <= acc_next;
      end
    end
  end

endmodule

// File: rtl/ber_period_monitor.sv
module ber_period_monitor
  import ber_mon_pkg::*;
#(
  parameter int INNER_MOD = 1000,
  parameter int PERIOD_W  = 24,
  parameter int ACC_W     = 16,
  parameter int PRE_LOG2  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic                rate_third,
  input  logic                err_g1,
  input  logic                err_g2,
  input  logic                err_g3,
  input  logic [PERIOD_W-1:0] period_cfg,
  output logic [2:0]          sym_err,
  output logic                bit_err,
  output logic [ACC_W-1:0]    ber_count,
  output logic                ber_irq
);

  sym_flags_t       flags_in;
  sym_flags_t       flags_q;
  logic             err_event;
  logic             meas_on;
  logic             period_end;
  logic             pre_carry;
  logic             idle_clear;
  logic [ACC_W-1:0] acc_level;

  assign flags_in   = '{g3: err_g3, g2: err_g2, g1: err_g1};
  assign idle_clear = !meas_on;

  ber_flag_stage u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .rate_third (rate_third),
    .flags_in   (flags_in),
    .flags_q    (flags_q),
    .bit_err_q  (bit_err),
    .err_event  (err_event)
  );

  ber_period_counter #(.INNER_MOD(INNER_MOD), .PERIOD_W(PERIOD_W)) u_period (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .period_cfg (period_cfg),
    .meas_on    (meas_on),
    .period_end (period_end)
  );

  ber_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .err_event (err_event && meas_on),
    .clear     (period_end || idle_clear),
    .carry     (pre_carry)
  );

  ber_accumulator #(.ACC_W(ACC_W)) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc        (pre_carry),
    .clear      (idle_clear),
    .period_end (period_end),
    .acc_level  (acc_level),
    .count_q    (ber_count),
    .irq_q      (ber_irq)
  );

  assign sym_err = flags_q;

endmodule

// File: rtl/ber_period_monitor_sva.sv
module ber_period_monitor_sva #(
  parameter int INNER_MOD = 1000,
  parameter int PERIOD_W  = 24,
  parameter int ACC_W     = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bit_valid,
  input logic [PERIOD_W-1:0] period_cfg,
  input logic [2:0]          sym_err,
  input logic                bit_err,
  input logic [ACC_W-1:0]    ber_count,
  input logic                ber_irq,
  input logic                period_end,
  input logic [ACC_W-1:0]    acc_level
);

  assert_flags_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(sym_err));

  assert_bit_err_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> $stable(bit_err));

  assert_bit_err_needs_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bit_err |-> (sym_err != 3'b000));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((acc_level == '1) && !period_end) |=> ((acc_level == '1) || (period_cfg == '0)));

  assert_irq_after_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> ber_irq);

  assert_irq_needs_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ber_irq |-> $past(bit_valid));

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((INNER_MOD > 1) && ber_irq) |=> !ber_irq);

  assert_disabled_no_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (period_cfg == '0) |-> !period_end);

  assert_count_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ber_irq |-> $stable(ber_count));

endmodule

bind ber_period_monitor ber_period_monitor_sva #(
  .INNER_MOD (INNER_MOD),
  .PERIOD_W  (PERIOD_W),
  .ACC_W     (ACC_W)
) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_valid  (bit_valid),
  .period_cfg (period_cfg),
  .sym_err    (sym_err),
  .bit_err    (bit_err),
  .ber_count  (ber_count),
  .ber_irq    (ber_irq),
  .period_end (period_end),
  .acc_level  (acc_level)
);

// File: tb/ber_period_monitor_tb.sv
`timescale 1ns/1ps
module ber_period_monitor_tb;

  localparam int INNER = 4;
  localparam int PW    = 24;
  localparam int AW    = 8;
  localparam int CMAX  = (1 << AW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bit_valid = 1'b0;
  logic          rate_third = 1'b0;
  logic          err_g1 = 1'b0, err_g2 = 1'b0, err_g3 = 1'b0;
  logic [PW-1:0] period_cfg = '0;
  logic [2:0]    sym_err;
  logic          bit_err;
  logic [AW-1:0] ber_count;
  logic          ber_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int m_bits = 0, m_errs = 0, m_count = 0;
  logic [2:0] m_flags = 3'b000;
  logic       m_berr  = 1'b0;
  bit done = 0;

  always #2 clk = ~clk;

  ber_period_monitor #(.INNER_MOD(INNER), .PERIOD_W(PW), .ACC_W(AW), .PRE_LOG2(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rate_third(rate_third),
    .err_g1(err_g1), .err_g2(err_g2), .err_g3(err_g3), .period_cfg(period_cfg),
    .sym_err(sym_err), .bit_err(bit_err), .ber_count(ber_count), .ber_irq(ber_irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle; v selects a decoded bit or an idle cycle. Model restated arithmetically.
  task automatic step(input bit v, input bit g1, input bit g2, input bit g3, input bit r3);
    int exp_irq;
    @(negedge clk);
    bit_valid = v; err_g1 = g1; err_g2 = g2; err_g3 = g3; rate_third = r3;
    exp_irq = 0;
    if (v) begin
      m_flags = {g3, g2, g1};
      m_berr  = g1 | g2 | (g3 & r3);
      if (period_cfg != 0) begin
        m_bits++;
        if (m_berr) m_errs++;
        if (m_bits == INNER * int'(period_cfg)) begin
          m_count = ((m_errs / 8) > CMAX) ? CMAX : (m_errs / 8);
          exp_irq = 1;
          m_bits = 0; m_errs = 0;
        end
      end
    end
    @(posedge clk); #1;
    check("R2 sym_err", int'(sym_err), int'(m_flags));
    check("R3 bit_err", int'(bit_err), int'(m_berr));
    check("R7 ber_irq", int'(ber_irq), exp_irq);
    check("R10 ber_count", int'(ber_count), m_count);
  endtask

  task automatic set_cfg(input int c);
    @(negedge clk);
    bit_valid = 1'b0;
    period_cfg = PW'(c);
    m_bits = 0; m_errs = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 count", int'(ber_count), 0);
    check("R1 irq", int'(ber_irq), 0);
    check("R1 sym_err", int'(sym_err), 0);
    check("R1 bit_err", int'(bit_err), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3/R9: exhaustive flag and rate sweep with measurement disabled.
    for (int k = 0; k < 16; k++) begin
      step(1'b1, k[0], k[1], k[2], k[3]);
      step(1'b0, ~k[0], ~k[1], ~k[2], ~k[3]);
    end
    check("R9 count stays zero", int'(ber_count), 0);

    // R4/R5: one window of 12 bits, 7 errors -> 0 (truncated).
    set_cfg(3);
    for (int b = 0; b < 12; b++) begin
      step(1'b1, b < 7, 1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b1, 1'b1, 1'b1); // R4 idle cycles do not advance
    end
    check("R5 seven errors truncate", int'(ber_count), 0);

    // R5: 12 errors -> 1; remainder must not carry into the next window.
    for (int b = 0; b < 12; b++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R5 twelve errors", int'(ber_count), 1);
    for (int b = 0; b < 12; b++) step(1'b1, 1'b0, 1'b0, b >= 8, 1'b1);
    check("R5 remainder dropped", int'(ber_count), 0);

    // R8: 7 errors then one on the final bit -> 1.
    for (int b = 0; b < 12; b++) step(1'b1, 1'b0, (b < 7) || (b == 11), 1'b0, 1'b0);
    check("R8 final bit counted", int'(ber_count), 1);

    // R3 at window level: g3 ignored at two-symbol rate.
    for (int b = 0; b < 12; b++) step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R3 g3 ignored", int'(ber_count), 0);

    // R4: shortest window (4 bits), every bit wrong, repeated.
    set_cfg(1);
    for (int b = 0; b < 16; b++) step(1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    check("R4 short windows", int'(ber_count), 0);

    // R9: disable mid-window clears partial state.
    set_cfg(2);
    for (int b = 0; b < 5; b++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    set_cfg(0);
    step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    set_cfg(2);
    for (int b = 0; b < 8; b++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R9 partial window discarded", int'(ber_count), 1);

    // R6: 2400 errors -> 300, saturates at 255.
    set_cfg(600);
    for (int b = 0; b < 2400; b++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    check("R6 saturation", int'(ber_count), CMAX);
    for (int b = 0; b < 2400; b++) step(1'b1, b < 16, 1'b0, 1'b0, 1'b0);
    check("R6 fresh after saturation", int'(ber_count), 2);

    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 50000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("Result: errors=%0d of %0d checks", n_fail, n_checks);
    $finish;
  end

endmodule